// File: doc/BRIEF.md
# Accumulator ALU with Registered Bus Operand

This block is the arithmetic datapath of a small accumulator machine. A memory operand reaches it over an external data bus whose value is trustworthy only at the moment the bus cycle ends. The block does not feed that value straight into the ALU. It first captures the bus value into an internal operand register on the end-of-cycle strobe. In the following clock cycle the ALU combines the accumulator with that held operand, and the result goes back to the accumulator.

A caller issues a start request together with a 3-bit operation code. The block then waits, for as many cycles as needed, for the bus-cycle-end strobe. On the clock edge that carries the strobe it latches the bus. During the next cycle it raises busy and evaluates the ALU. At the end of that cycle it writes the accumulator and the flags. Because the ALU sees only two registered inputs, its logic depth is separate from the bus timing.

Top module: `acc_alu_unit`

## Requirements
- R1: While the synchronous active-low reset is held, the accumulator, the operand register and the flags clear to zero and busy is low.
- R2: A start request taken while idle stores the operation code and arms the capture. A bus-cycle-end strobe with no armed request is ignored and leaves the accumulator and flags unchanged.
- R3: The operand register takes the bus value on the clock edge where the strobe is high while armed. Bus values after that edge do not change the result.
- R4: Busy is high for exactly the one cycle after the capture edge. The accumulator and flags are written on the edge that ends that cycle and hold their values at every other time.
- R5: Operation code 0 (add) writes accumulator plus operand, modulo 2^W, and sets carry to the carry out.
- R6: Operation code 1 (subtract) writes accumulator minus operand, modulo 2^W, and sets carry when a borrow occurs (accumulator below operand).
- R7: Operation codes 2, 3 and 4 (AND, OR, XOR) write the bitwise result and clear carry.
- R8: Operation code 5 (compare) sets the flags exactly as subtract would and leaves the accumulator unchanged.
- R9: The flags output is {sign, zero, parity, carry} from bit 3 down to bit 0. Sign is the result's top bit. Zero is set when the result is zero. Parity is set when the result has an even number of one bits.
- R10: Operation codes 6 and 7 still take the busy cycle, but they change neither the accumulator nor the flags.
- R11: While busy, start requests and strobes are ignored. While armed, a further start request does not replace the stored operation code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to run one operation |
| op_i | input | 3 | Operation code, sampled with start_i |
| bus_data_i | input | W | External data bus carrying the operand |
| bus_end_i | input | 1 | Bus-cycle-end strobe; bus data valid on this edge |
| acc_o | output | W | Accumulator |
| flags_o | output | 4 | {sign, zero, parity, carry} |
| busy_o | output | 1 | High during the ALU/write-back cycle |

## Verification
The bench builds the block with W = 8. At that width, carry out of 0xFF, borrow down to 0xFF, and results of exactly zero can all be reached with a handful of chosen operands. The vector sequence chains operations so that each step starts from the accumulator the previous one left. It alters the bus right after every capture, so a result that leaked from a late bus value would show up. Directed cases cover strobes while idle, start and strobe while busy, a second start while armed, a long wait before the strobe, and reset in the middle of an operation.

// File: rtl/acc_alu_pkg.sv
// Shared definitions for the accumulator ALU: operation codes, sequencer
// states and flag bit positions. Assumes a 3-bit operation code.
package acc_alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_CMP  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2
    } seq_state_e;

    localparam int FLAG_W   = 4;
    localparam int FLAG_SGN = 3;
    localparam int FLAG_ZER = 2;
    localparam int FLAG_PAR = 1;
    localparam int FLAG_CRY = 0;
endpackage

// File: rtl/alu_opnd_latch.sv
// Operand holding register. It loads the bus value on a capture pulse and
// keeps it otherwise. Assumes the capture pulse coincides with the edge at
// which bus data is valid.
module alu_opnd_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Hold register: clear on reset, load on capture.
    always_ff @(posedge clk) begin
        if (!rst_n)         q_o <= '0;
        else if (capture_i) q_o <= d_i;
    end
endmodule

// File: rtl/alu_seq.sv
// Sequencer: idle -> armed (waiting for bus end) -> execute (one cycle).
// Stores the operation code on an accepted start request. Assumes start and
// strobe are synchronous to clk.
module alu_seq
    import acc_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [2:0] op_i,
    input  logic       bus_end_i,
    output logic       capture_o,
    output logic       exec_o,
    output logic       armed_o,
    output logic [2:0] op_q_o
);
    seq_state_e state_q, state_d;

    // Capture only when armed and the bus cycle ends.
    assign capture_o = (state_q == ST_WAIT) && bus_end_i;
    assign exec_o    = (state_q == ST_EXEC);
    assign armed_o   = (state_q == ST_WAIT);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start_i)   state_d = ST_WAIT;
            ST_WAIT: if (bus_end_i) state_d = ST_EXEC;
            ST_EXEC:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register and operation-code store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q_o  <= 3'd0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) op_q_o <= op_i;
        end
    end
endmodule

// File: rtl/alu_core.sv
// Combinational ALU over two registered inputs. It produces the result, the
// new flags and write enables. Assumes both inputs are stable for the cycle.
module alu_core
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      acc_i,
    input  logic [W-1:0]      opnd_i,
    input  logic [2:0]        op_i,
    output logic [W-1:0]      res_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              wr_acc_o,
    output logic              wr_flags_o
);
    logic [W:0] sum;
    logic [W:0] diff;
    logic       cy;

    // Operation select, carry/borrow and write enables.
    always_comb begin
        sum        = {1'b0, acc_i} + {1'b0, opnd_i};
        diff       = {1'b0, acc_i} - {1'b0, opnd_i};
        res_o      = acc_i;
        cy         = 1'b0;
        wr_acc_o   = 1'b0;
        wr_flags_o = 1'b1;
        case (alu_op_e'(op_i))
            OP_ADD: begin res_o = sum[W-1:0];  cy = sum[W];  wr_acc_o = 1'b1; end
            OP_SUB: begin res_o = diff[W-1:0]; cy = diff[W]; wr_acc_o = 1'b1; end
            OP_AND: begin res_o = acc_i & opnd_i; wr_acc_o = 1'b1; end
            OP_OR:  begin res_o = acc_i | opnd_i; wr_acc_o = 1'b1; end
            OP_XOR: begin res_o = acc_i ^ opnd_i; wr_acc_o = 1'b1; end
            OP_CMP: begin res_o = diff[W-1:0]; cy = diff[W]; end
            default: wr_flags_o = 1'b0;
        endcase
    end

    // Flag formation from the result.
    always_comb begin
        flags_o           = '0;
        flags_o[FLAG_SGN] = res_o[W-1];
        flags_o[FLAG_ZER] = (res_o == '0);
        flags_o[FLAG_PAR] = ~^res_o;
        flags_o[FLAG_CRY] = cy;
    end
endmodule

// File: rtl/acc_alu_unit.sv
// Top: accumulator and flag registers, with the operand latch, sequencer and
// ALU core. Bus data is used only through the operand register, one cycle
// after capture. Assumes bus_data_i is valid on the edge carrying bus_end_i.
module acc_alu_unit
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [W-1:0]      bus_data_i,
    input  logic              bus_end_i,
    output logic [W-1:0]      acc_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              busy_o
);
    logic              capture;
    logic              exec;
    logic              armed;
    logic [2:0]        op_q;
    logic [W-1:0]      opnd_q;
    logic [W-1:0]      res;
    logic [FLAG_W-1:0] flags_new;
    logic              wr_acc;
    logic              wr_flags;

    alu_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op_i),
        .bus_end_i (bus_end_i),
        .capture_o (capture),
        .exec_o    (exec),
        .armed_o   (armed),
        .op_q_o    (op_q)
    );

    alu_opnd_latch #(.W(W)) u_opnd (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .d_i       (bus_data_i),
        .q_o       (opnd_q)
    );

    alu_core #(.W(W)) u_core (
        .acc_i      (acc_o),
        .opnd_i     (opnd_q),
        .op_i       (op_q),
        .res_o      (res),
        .flags_o    (flags_new),
        .wr_acc_o   (wr_acc),
        .wr_flags_o (wr_flags)
    );

    assign busy_o = exec;

    // Accumulator and flag write-back in the execute cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o   <= '0;
            flags_o <= '0;
        end else if (exec) begin
            if (wr_acc)   acc_o   <= res;
            if (wr_flags) flags_o <= flags_new;
        end
    end
endmodule

// File: rtl/acc_alu_unit_chk.sv
// Checker for acc_alu_unit, attached by bind. Watches ports and the
// sequencer/latch outputs for timing rules.
module acc_alu_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         armed,
    input logic         bus_end,
    input logic [2:0]   op_q,
    input logic [W-1:0] opnd,
    input logic [W-1:0] acc,
    input logic [3:0]   flags
);
    // R1: reset clears accumulator, flags and operand.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (acc == '0 && flags == '0 && opnd == '0 && !busy));

    // R3: an armed strobe leads to the execute cycle.
    a_r3_capture_to_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bus_end) |=> busy);

    // R4: busy lasts exactly one cycle.
    a_r4_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R4: accumulator and flags hold outside the write cycle.
    a_r4_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(acc) && $stable(flags)));

    // R3: operand held through the execute cycle despite bus activity.
    a_r3_opnd_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(opnd));

    // R8: compare leaves the accumulator alone.
    a_r8_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q == 3'd5) |=> $stable(acc));

    // R10: reserved codes change neither accumulator nor flags.
    a_r10_rsv_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q[2:1] == 2'b11) |=> ($stable(acc) && $stable(flags)));
endmodule

bind acc_alu_unit acc_alu_unit_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_o),
    .armed   (armed),
    .bus_end (bus_end_i),
    .op_q    (op_q),
    .opnd    (opnd_q),
    .acc     (acc_o),
    .flags   (flags_o)
);

// File: tb/tb_acc_alu_unit.sv
module tb_acc_alu_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [2:0]   op_i = 3'd0;
    logic [W-1:0] bus_data_i = '0;
    logic         bus_end_i = 1'b0;
    logic [W-1:0] acc_o;
    logic [3:0]   flags_o;
    logic         busy_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    acc_alu_unit #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .bus_data_i(bus_data_i), .bus_end_i(bus_end_i),
        .acc_o(acc_o), .flags_o(flags_o), .busy_o(busy_o)
    );

    // Vector: {op[22:20], operand[19:12], exp_acc[11:4], exp_flags{S,Z,P,C}[3:0]}
    localparam int NV = 14;
    localparam logic [22:0] VEC [NV] = '{
        {3'd0, 8'h3C, 8'h3C, 4'h2},  // R5 add
        {3'd0, 8'hF0, 8'h2C, 4'h1},  // R5 add with carry out
        {3'd1, 8'h2D, 8'hFF, 4'hB},  // R6 borrow
        {3'd2, 8'h0F, 8'h0F, 4'h2},  // R7 and, carry cleared
        {3'd3, 8'h80, 8'h8F, 4'h8},  // R7 or
        {3'd4, 8'h8F, 8'h00, 4'h6},  // R7 xor to zero
        {3'd0, 8'h7F, 8'h7F, 4'h0},  // R9 odd parity
        {3'd5, 8'h7F, 8'h7F, 4'h6},  // R8 compare equal
        {3'd5, 8'h80, 8'h7F, 4'hB},  // R8 compare below
        {3'd1, 8'h7F, 8'h00, 4'h6},  // R6 subtract to zero
        {3'd0, 8'h01, 8'h01, 4'h0},  // R5
        {3'd1, 8'h01, 8'h00, 4'h6},  // R6
        {3'd4, 8'h55, 8'h55, 4'h2},  // R7 xor
        {3'd6, 8'hAA, 8'h55, 4'h2}   // R10 reserved code
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One operation; bus changes right after capture (R3).
    task automatic run_op(input logic [2:0] op, input logic [W-1:0] d, input int gap,
                          output logic busy_seen);
        @(negedge clk); start_i = 1'b1; op_i = op;
        @(negedge clk); start_i = 1'b0; op_i = 3'd7;
        for (int i = 0; i < gap; i++) @(negedge clk);
        bus_data_i = d; bus_end_i = 1'b1;
        @(negedge clk); bus_end_i = 1'b0; bus_data_i = ~d;
        busy_seen = busy_o;
        @(negedge clk);
    endtask

    initial begin
        logic b;
        logic [7:0] acc_save;
        logic [3:0] fl_save;
        repeat (3) @(negedge clk);
        chk("R1 acc", acc_o, 8'h00);
        chk("R1 flags", flags_o, 4'h0);
        chk("R1 busy", busy_o, 1'b0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][22:20], VEC[v][19:12], 0, b);
            chk("R4 busy after capture", b, 1'b1);
            chk("R4 busy cleared", busy_o, 1'b0);
            chk("R5-vector acc", acc_o, VEC[v][11:4]);
            chk("R9 flags", flags_o, VEC[v][3:0]);
        end

        // R2: strobe while idle is ignored
        @(negedge clk); bus_data_i = 8'h11; bus_end_i = 1'b1;
        @(negedge clk); bus_end_i = 1'b0;
        chk("R2 no busy on idle strobe", busy_o, 1'b0);
        @(negedge clk);
        chk("R2 acc unchanged", acc_o, 8'h55);
        chk("R2 flags unchanged", flags_o, 4'h2);

        // R2/R3: long wait before strobe
        run_op(3'd0, 8'h01, 4, b);
        chk("R2 delayed capture acc", acc_o, 8'h56);
        chk("R9 delayed flags", flags_o, 4'h2);

        // R11: second start while armed does not replace op (ADD kept, not SUB)
        @(negedge clk); start_i = 1'b1; op_i = 3'd0;
        @(negedge clk); op_i = 3'd1;
        @(negedge clk); start_i = 1'b0; bus_data_i = 8'h02; bus_end_i = 1'b1;
        @(negedge clk); bus_end_i = 1'b0;
        // R11: start and strobe during busy are ignored
        start_i = 1'b1; op_i = 3'd2; bus_end_i = 1'b1; bus_data_i = 8'h00;
        @(negedge clk); start_i = 1'b0; bus_end_i = 1'b0;
        chk("R11 op kept while armed", acc_o, 8'h58);
        chk("R11 not busy", busy_o, 1'b0);
        @(negedge clk); bus_end_i = 1'b1; bus_data_i = 8'h00;
        @(negedge clk); bus_end_i = 1'b0;
        @(negedge clk);
        chk("R11 busy start ignored", acc_o, 8'h58);
        chk("R11 busy stays low", busy_o, 1'b0);

        // R1: reset mid-operation
        acc_save = acc_o; fl_save = flags_o;
        @(negedge clk); start_i = 1'b1; op_i = 3'd0;
        @(negedge clk); start_i = 1'b0; bus_data_i = 8'h10; bus_end_i = 1'b1;
        @(negedge clk); bus_end_i = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-op acc", acc_o, 8'h00);
        chk("R1 reset mid-op flags", flags_o, 4'h0);
        chk("R1 reset mid-op busy", busy_o, 1'b0);
        rst_n = 1'b1;
        // R1: operand cleared, so compare with 0 gives zero flag on zero acc
        run_op(3'd5, 8'h00, 0, b);
        chk("R8 cmp after reset", flags_o, 4'h6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule